// File: doc/BRIEF.md
# Smart Card Character Transceiver with Automatic Retransmission

This block sends and receives single characters over one shared open-drain data line of the kind found on contact smart cards. It never drives the line high. It only asserts a pull-low enable and reads the resolved line level back. Each character is one elementary time unit (ETU) per bit: a low start bit, eight data bits with the least significant first, and one parity bit. Parity sense is set by a control pin.

On the receive side, every character's parity is checked. A good character goes to the host through a valid/ready output. A bad one is discarded, and the receiver answers by holding the line low for a fixed window after the character, which asks the sender to repeat it. On the transmit side, the line is watched during that window. If the error pulse is seen, the same character is sent again. Otherwise the transmitter is free for the next byte. The number of retransmissions is capped, and running past the cap ends the attempt with a failure pulse.

Back-pressure works as follows. The transmit input accepts a byte only when `tx_valid` and `tx_ready` are both high at a clock edge. `tx_ready` stays low for the whole of any transmit or receive frame, and a waiting `tx_valid` simply stalls. On the receive output, `rx_valid` and `rx_data` hold until `rx_ready` is seen high at an edge. A character that completes while an earlier one is still waiting is dropped.

Top module: `sc_char_xcvr`

## Requirements
- R1: After a byte is accepted, `line_drive_low` gives the start bit, then data bits 0 through 7, then the parity bit, each for ETU_CYCLES clocks, beginning in the cycle after the accepting edge. The pin is 1 when the bit value is 0.
- R2: With `odd_parity`=0 the parity bit equals the XOR of the eight data bits, and with `odd_parity`=1 it is that XOR inverted. This holds both for the bit sent and for the bit checked on receive.
- R3: The transmitter samples the line exactly 1 ETU after its parity bit ends, which is clock 11·E of the frame, where E is ETU_CYCLES and clock 0 is the first start-bit cycle. If the line is low, `err_seen` pulses for one cycle at clock 11·E+1 and the same character is sent again starting at clock 13·E.
- R4: If no error pulse is sampled, no retransmission follows, `line_drive_low` stays 0 after the parity bit, and `tx_ready` is high again at clock 13·E.
- R5: After RETRY_MAX retransmissions, a further sampled error pulse makes `tx_fail` pulse for one cycle at clock 13·E of that attempt, together with `tx_ready` returning high. Nothing more is sent.
- R6: While idle, a low line starts reception. Each bit is sampled at the middle of its ETU. A character with correct parity raises `rx_valid` with that byte on `rx_data` and causes no line drive.
- R7: A character with wrong parity is not delivered. `parity_err` pulses for one cycle. The block pulls the line low from 10.5·E to 12·E clocks after the start edge, then releases it, and it stays busy until 13·E.
- R8: `rx_valid` and `rx_data` stay unchanged until `rx_ready` is high at an edge. A character completed while `rx_valid` is high is dropped.
- R9: The block is half duplex. `tx_ready` is low throughout any transmit or receive frame, and the receiver ignores the line, including the block's own start bit, while transmitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| odd_parity | input | 1 | 0 selects even parity, 1 selects odd parity |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte can be taken |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte held for the host |
| rx_ready | input | 1 | Host takes the received byte |
| line_in | input | 1 | Resolved level of the shared line |
| line_drive_low | output | 1 | Pull the shared line low |
| err_seen | output | 1 | One-cycle pulse: error pulse sampled after a sent character |
| parity_err | output | 1 | One-cycle pulse: received character failed parity |
| tx_fail | output | 1 | One-cycle pulse: retry limit exhausted |

## Verification
The assertions assume that `rx_ready` and `tx_valid` are stable between clock edges. They also assume that the far end never pulls the line low during the block's own start and data bits, and that it begins a character only while the block is idle. The bench resolves the line as the wired-AND of the two pull-low enables and changes all stimulus at falling edges. The card model drives its frames bit-aligned to whole ETUs and places its error pulse only inside the window after a character the block has sent.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int FRAME_BITS = 10;

  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_GUARD} tx_state_t;
  typedef enum logic [1:0] {RX_IDLE, RX_BITS} rx_state_t;

  function automatic logic parity_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/sc_etu_count.sv
module sc_etu_count #(
  parameter int ETU = 8,
  localparam int EW = $clog2(ETU)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [EW-1:0] start_val,
  input  logic          run,
  output logic [EW-1:0] ecnt,
  output logic [3:0]    bidx
);
  localparam logic [EW-1:0] LAST = EW'(ETU - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt <= '0;
      bidx <= '0;
    end else if (restart) begin
      ecnt <= start_val;
      bidx <= '0;
    end else if (run) begin
      if (ecnt == LAST) begin
        ecnt <= '0;
        bidx <= bidx + 4'd1;
      end else begin
        ecnt <= ecnt + EW'(1);
      end
    end
  end
endmodule

// File: rtl/sc_tx_engine.sv
module sc_tx_engine
  import sc_pkg::*;
#(
  parameter int ETU       = 8,
  parameter int RETRY_MAX = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       odd_parity,
  input  logic       allow,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic       line_in,
  output logic       drive_low,
  output logic       busy,
  output logic       err_seen,
  output logic       tx_fail
);
  localparam int EW = $clog2(ETU);
  localparam int RW = $clog2(RETRY_MAX + 2);
  localparam logic [EW-1:0] LAST = EW'(ETU - 1);

  tx_state_t               st;
  logic [FRAME_BITS-1:0]   frame_q, shreg, new_frame;
  logic [RW-1:0]           retries;
  logic                    err_q;
  logic [EW-1:0]           ecnt;
  logic [3:0]              bidx;
  logic                    accept, unit_end, sample_pt, decide_pt, retry_go;

  assign tx_ready  = (st == TX_IDLE) && allow;
  assign busy      = (st != TX_IDLE);
  assign accept    = tx_valid && tx_ready;
  assign unit_end  = (ecnt == LAST);
  assign sample_pt = (st == TX_GUARD) && (bidx == 4'd11) && (ecnt == '0);
  assign decide_pt = (st == TX_GUARD) && (bidx == 4'd12) && unit_end;
  assign retry_go  = decide_pt && err_q && (retries != RW'(RETRY_MAX));
  assign new_frame = {parity_of(tx_data, odd_parity), tx_data, 1'b0};
  assign drive_low = (st == TX_SEND) && !shreg[0];

  sc_etu_count #(.ETU(ETU)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(accept || retry_go),
    .start_val('0), .run(busy), .ecnt(ecnt), .bidx(bidx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TX_IDLE;
      frame_q  <= '1;
      shreg    <= '1;
      retries  <= '0;
      err_q    <= 1'b0;
      err_seen <= 1'b0;
      tx_fail  <= 1'b0;
    end else begin
      err_seen <= 1'b0;
      tx_fail  <= 1'b0;
      case (st)
        TX_IDLE: if (accept) begin
          frame_q <= new_frame;
          shreg   <= new_frame;
          retries <= '0;
          err_q   <= 1'b0;
          st      <= TX_SEND;
        end
        TX_SEND: if (unit_end) begin
          shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
          if (bidx == 4'd9) st <= TX_GUARD;
        end
        TX_GUARD: begin
          if (sample_pt) begin
            err_q    <= !line_in;
            err_seen <= !line_in;
          end
          if (retry_go) begin
            retries <= retries + RW'(1);
            shreg   <= frame_q;
            err_q   <= 1'b0;
            st      <= TX_SEND;
          end else if (decide_pt) begin
            tx_fail <= err_q;
            st      <= TX_IDLE;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  a_r1_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !tx_ready);
  a_r3_err_inside_guard: assert property (@(posedge clk) disable iff (!rst_n)
    err_seen |-> st == TX_GUARD);
  a_r5_fail_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fail |-> !busy && !drive_low);
endmodule

// File: rtl/sc_rx_engine.sv
module sc_rx_engine
  import sc_pkg::*;
#(
  parameter int ETU = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       odd_parity,
  input  logic       enable,
  input  logic       line_in,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic       parity_err,
  output logic       drive_low,
  output logic       busy
);
  localparam int EW = $clog2(ETU);
  localparam logic [EW-1:0] LAST = EW'(ETU - 1);
  localparam logic [EW-1:0] MID  = EW'(ETU / 2);

  rx_state_t   st;
  logic [7:0]  shreg;
  logic        bad_q;
  logic [EW-1:0] ecnt;
  logic [3:0]  bidx;
  logic        start_det, mid_pt, frame_end;

  assign busy      = (st == RX_BITS);
  assign start_det = (st == RX_IDLE) && enable && !line_in;
  assign mid_pt    = busy && (ecnt == MID);
  assign frame_end = busy && unit_is_last();
  assign drive_low = busy && bad_q &&
                     (((bidx == 4'd10) && (ecnt >= MID)) || (bidx == 4'd11));

  function automatic logic unit_is_last();
    return (ecnt == LAST) && (bad_q ? (bidx == 4'd12) : (bidx == 4'd10));
  endfunction

  sc_etu_count #(.ETU(ETU)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(start_det),
    .start_val(EW'(1)), .run(busy), .ecnt(ecnt), .bidx(bidx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RX_IDLE;
      shreg      <= '0;
      bad_q      <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      parity_err <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (start_det) begin
        st    <= RX_BITS;
        bad_q <= 1'b0;
      end else if (busy) begin
        if (mid_pt && (bidx >= 4'd1) && (bidx <= 4'd8))
          shreg <= {line_in, shreg[7:1]};
        if (mid_pt && (bidx == 4'd9)) begin
          if (line_in != parity_of(shreg, odd_parity)) begin
            bad_q      <= 1'b1;
            parity_err <= 1'b1;
          end else if (!rx_valid) begin
            rx_valid <= 1'b1;
            rx_data  <= shreg;
          end
        end
        if (frame_end) st <= RX_IDLE;
      end
    end
  end

  a_r8_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
  a_r7_bad_not_delivered: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> !$rose(rx_valid));
  a_r7_pulse_only_after_error: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> busy && !parity_err);
endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr #(
  parameter int ETU_CYCLES = 8,
  parameter int RETRY_MAX  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       odd_parity,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  input  logic       line_in,
  output logic       line_drive_low,
  output logic       err_seen,
  output logic       parity_err,
  output logic       tx_fail
);
  logic tx_busy, rx_busy, tx_drive, rx_drive;

  sc_tx_engine #(.ETU(ETU_CYCLES), .RETRY_MAX(RETRY_MAX)) u_tx (
    .clk(clk), .rst_n(rst_n), .odd_parity(odd_parity), .allow(!rx_busy),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .line_in(line_in), .drive_low(tx_drive), .busy(tx_busy),
    .err_seen(err_seen), .tx_fail(tx_fail)
  );

  sc_rx_engine #(.ETU(ETU_CYCLES)) u_rx (
    .clk(clk), .rst_n(rst_n), .odd_parity(odd_parity), .enable(!tx_busy),
    .line_in(line_in), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .parity_err(parity_err), .drive_low(rx_drive),
    .busy(rx_busy)
  );

  assign line_drive_low = tx_drive || rx_drive;

  a_r9_single_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_busy && rx_busy));
  a_r9_no_offer_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy || rx_busy) |-> !tx_ready);
endmodule

// File: tb/test_sc_char_xcvr.sv
`timescale 1ns/1ps
module test_sc_char_xcvr;
  localparam int E  = 8;
  localparam int RM = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic odd_parity = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [7:0] rx_data;
  logic rx_valid;
  logic rx_ready = 1'b0;
  logic line_in;
  logic line_drive_low;
  logic err_seen, parity_err, tx_fail;
  logic card_drive = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic exp_rxv = 1'b0;
  logic [7:0] exp_rxd = '0;

  always #2.5 clk = ~clk;
  assign line_in = !(line_drive_low || card_drive);

  sc_char_xcvr #(.ETU_CYCLES(E), .RETRY_MAX(RM)) i_sc_char_xcvr (
    .clk(clk), .rst_n(rst_n), .odd_parity(odd_parity),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .line_in(line_in), .line_drive_low(line_drive_low),
    .err_seen(err_seen), .parity_err(parity_err), .tx_fail(tx_fail)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic par(input logic [7:0] d, input logic odd);
    return odd ? ~^d : ^d;
  endfunction

  function automatic logic frame_bit(input int k, input logic [7:0] d, input logic p);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    return p;
  endfunction

  task automatic rx_side_quiet(input string req);
    chk(req, "rx_valid", rx_valid, exp_rxv);
    chk(req, "parity_err", parity_err, 0);
  endtask

  // Transmit one byte; the card pulls an error pulse on the first nerr attempts.
  task automatic send_byte(input logic [7:0] d, input logic odd, input int nerr);
    int attempts;
    logic fail;
    logic p;
    fail = (nerr > RM);
    attempts = fail ? RM + 1 : nerr + 1;
    p = par(d, odd);
    @(negedge clk);
    odd_parity = odd;
    tx_data = d;
    tx_valid = 1'b1;
    chk("R9", "tx_ready idle", tx_ready, 1);
    for (int a = 0; a < attempts; a++) begin
      for (int t = 0; t < 13 * E; t++) begin
        logic inj;
        @(negedge clk);
        tx_valid = 1'b0;
        inj = (a < nerr);
        card_drive = inj && (t >= 10 * E + E / 2) && (t < 12 * E);
        if (t < 10 * E)
          chk("R1", $sformatf("bit t=%0d", t), line_drive_low, !frame_bit(t / E, d, p));
        else
          chk("R4", $sformatf("released t=%0d", t), line_drive_low, 0);
        chk("R3", $sformatf("err_seen t=%0d", t), err_seen, inj && (t == 11 * E + 1));
        chk("R9", "tx_ready busy", tx_ready, 0);
        chk("R5", "tx_fail early", tx_fail, 0);
        rx_side_quiet("R9");
      end
    end
    @(negedge clk);
    card_drive = 1'b0;
    chk("R4", "tx_ready after frame", tx_ready, 1);
    chk("R5", "tx_fail", tx_fail, fail);
    chk("R4", "line idle", line_drive_low, 0);
  endtask

  // The card sends one character; bad flips its parity bit.
  task automatic card_sends(input logic [7:0] d, input logic odd, input logic bad);
    logic p;
    p = par(d, odd) ^ bad;
    odd_parity = odd;
    for (int j = 0; j < 13 * E; j++) begin
      logic prev;
      @(negedge clk);
      card_drive = (j < 10 * E) ? !frame_bit(j / E, d, p) : 1'b0;
      prev = exp_rxv;
      if (prev && rx_ready) exp_rxv = 1'b0;
      if ((j == 9 * E + E / 2 + 1) && !bad && !prev) begin
        exp_rxv = 1'b1;
        exp_rxd = d;
      end
      chk("R7", $sformatf("err drive j=%0d", j), line_drive_low,
          bad && (j >= 10 * E + E / 2) && (j < 12 * E));
      chk("R7", "parity_err", parity_err, bad && (j == 9 * E + E / 2 + 1));
      chk("R6", "rx_valid", rx_valid, exp_rxv);
      if (exp_rxv) chk("R8", "rx_data", rx_data, exp_rxd);
      chk("R9", "tx_ready", tx_ready, (j == 0) || (j >= (bad ? 13 * E : 11 * E)));
    end
    @(negedge clk);
    chk("R9", "idle after rx", tx_ready, 1);
  endtask

  task automatic drain(input logic [7:0] d);
    @(negedge clk);
    chk("R8", "held valid", rx_valid, 1);
    chk("R8", "held data", rx_data, d);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    exp_rxv = 1'b0;
    chk("R8", "taken", rx_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "reset tx_ready", tx_ready, 1);
    chk("R6", "reset rx_valid", rx_valid, 0);
    chk("R4", "reset drive", line_drive_low, 0);
    chk("R5", "reset flags", {err_seen, parity_err, tx_fail}, 0);

    send_byte(8'hA5, 1'b0, 0);   // R2 even
    send_byte(8'h3C, 1'b1, 0);   // R2 odd
    send_byte(8'h81, 1'b0, 1);   // R3 one retry
    send_byte(8'h5A, 1'b0, RM + 1); // R5 limit exhausted
    send_byte(8'hFF, 1'b1, RM);  // R5 success on last allowed retry

    card_sends(8'h96, 1'b0, 1'b0); // R6 even good
    drain(8'h96);
    card_sends(8'h41, 1'b1, 1'b1); // R7 bad parity
    card_sends(8'h12, 1'b0, 1'b0); // R8 first held
    card_sends(8'h34, 1'b0, 1'b0); // R8 dropped
    drain(8'h12);
    card_sends(8'h00, 1'b1, 1'b0); // R2 odd receive
    drain(8'h00);
    send_byte(8'h7E, 1'b1, 2);     // R3 after receive traffic

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule